// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and decides when the core must leave its instruction stream to service an interrupt. Four request lines come in, each tied to a fixed source index: a trap, a system call, an IO device and a program-raised request. The core pulses a strobe at the end of every instruction. At that point the controller checks which requests are live, unmasked and allowed by the global enable. It picks the most urgent one and returns the service routine address held in a small vector register file.

When an interrupt is taken, the controller saves the address of the next instruction together with the priority level that was in service. These go on a four-entry return stack. A request of strictly higher priority can therefore interrupt a running service routine. Requests of equal or lower priority wait until the current routine returns.

A return strobe from the core pops the stack. It hands back the saved address and restores the previous priority level. Software loads the vector registers and the mask register through simple write ports.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `take_o`, `ack_o` and `ret_valid_o` are low, every mask bit is 0 (all sources unmasked), no service is in progress and the return stack is empty.
- R2: A request is recognized only on a clock edge where `insn_end_i` is high. The outputs `take_o`, `src_o`, `ack_o` and `target_o` reflect that decision in the cycle after that edge, for exactly one cycle.
- R3: Source index 0 is trap, 1 is system call, 2 is IO device and 3 is program-raised. Bit n of `irq_req_i`, `mask_wdata_i` and `ack_o` belongs to index n. Lower index means higher priority, and the lowest eligible index is selected.
- R4: On a take, `target_o` equals the vector entry of the selected index. A write with `vec_we_i` stores `vec_wdata_i` into entry `vec_widx_i` and governs every take recognized on a later edge.
- R5: A mask bit of 1 stops its source from being recognized. The mask register is loaded from `mask_wdata_i` on an edge where `mask_we_i` is high.
- R6: While `glob_en_i` is low, no request is recognized.
- R7: On a take, `cur_pc_i + 1` (modulo 2^16) is saved. On a later return, that value appears on `ret_pc_o` together with `ret_valid_o`, one cycle after the `ret_strobe_i` edge.
- R8: While a service is in progress, only a source of strictly higher priority (lower index) than the one in service is recognized. Equal and lower priority requests stay pending until the level drops.
- R9: Returns pop in last-in first-out order across up to four nested levels. Each return restores the priority level that was in service before the matching take.
- R10: An edge with `ret_strobe_i` high recognizes no request, even when `insn_end_i` is also high. A return strobe with an empty stack produces no `ret_valid_o`.
- R11: On a take, `ack_o` has exactly one bit set: the bit of `src_o`. Otherwise `ack_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_end_i | input | 1 | End-of-instruction strobe from the core |
| glob_en_i | input | 1 | Global interrupt enable |
| irq_req_i | input | 4 | Level-sensitive request lines, bit n = source index n |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 4 | New mask value, 1 blocks a source |
| vec_we_i | input | 1 | Vector register write strobe |
| vec_widx_i | input | 2 | Vector entry to write |
| vec_wdata_i | input | 16 | Service routine address to store |
| cur_pc_i | input | 16 | Address of the instruction just completed |
| ret_strobe_i | input | 1 | Return-from-service strobe |
| take_o | output | 1 | One-cycle pulse: jump to `target_o` |
| src_o | output | 2 | Index of the source being taken |
| ack_o | output | 4 | One-hot acknowledge to the selected source |
| target_o | output | 16 | Service routine address |
| ret_valid_o | output | 1 | One-cycle pulse: resume at `ret_pc_o` |
| ret_pc_o | output | 16 | Restored return address |

## Verification
Assertions watch the per-cycle rules on every cycle:
- a take only follows an enabled end-of-instruction edge with no return strobe;
- the acknowledge is one-hot and matches the reported source;
- a masked source is never acknowledged;
- a return output only follows a return strobe;
- the return stack never overflows or underflows.

The bench scenarios show the rest:
- the choice among simultaneous requests;
- the vector and return-address values;
- nesting held off for equal or lower priority;
- last-in first-out unwinding with the restored priority level;
- address wraparound;
- the effect of rewriting a vector.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC   = 4;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int ADDR_W = 16;
    localparam int LVL_W  = IDX_W + 1;

    typedef logic [IDX_W-1:0]  src_idx_t;
    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NSRC-1:0]   src_vec_t;

    // level value meaning "nothing in service"
    localparam level_t LVL_IDLE = level_t'(NSRC);

    typedef enum logic [IDX_W-1:0] {
        SRC_TRAP    = 2'd0,
        SRC_SYSCALL = 2'd1,
        SRC_IODEV   = 2'd2,
        SRC_PROG    = 2'd3
    } src_kind_e;

    typedef struct packed {
        addr_t  ret_addr;
        level_t prev_lvl;
    } frame_t;

    function automatic src_vec_t idx_to_onehot(src_idx_t i);
        return src_vec_t'(1) << i;
    endfunction

endpackage

// File: rtl/vic_pick.sv
module vic_pick
    import vic_pkg::*;
(
    input  src_vec_t req_i,
    input  src_vec_t mask_i,
    input  level_t   level_i,
    output logic     valid_o,
    output src_idx_t idx_o
);
    src_vec_t elig;

    // a source is eligible when raised, unmasked and above the current level
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = req_i[i] && !mask_i[i] && (level_t'(i) < level_i);
        end
    end

    // scan from lowest priority up so the most urgent wins
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                valid_o = 1'b1;
                idx_o   = src_idx_t'(i);
            end
        end
    end

endmodule

// File: rtl/vic_vecfile.sv
module vic_vecfile
    import vic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  src_idx_t widx_i,
    input  addr_t    wdata_i,
    input  src_idx_t ridx_i,
    output addr_t    rdata_o
);
    addr_t entry_q [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (we_i && (widx_i == src_idx_t'(g))) begin
                entry_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = entry_q[ridx_i];

endmodule

// File: rtl/vic_rstack.sv
module vic_rstack
    import vic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  logic   pop_i,
    input  frame_t push_data_i,
    output frame_t top_o,
    output logic   empty_o,
    output logic   full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    frame_t           mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] top_ptr;

    assign wr_ptr  = PTR_W'(cnt_q);
    assign top_ptr = PTR_W'(cnt_q - CNT_W'(1));
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign top_o   = mem_q[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push_i) begin
            mem_q[wr_ptr] <= push_data_i;
            cnt_q         <= cnt_q + CNT_W'(1);
        end else if (pop_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);
    assert_single_op_R9: assert property (@(posedge clk) disable iff (rst)
        !(push_i && pop_i));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_end_i,
    input  logic        glob_en_i,
    input  logic [3:0]  irq_req_i,
    input  logic        mask_we_i,
    input  logic [3:0]  mask_wdata_i,
    input  logic        vec_we_i,
    input  logic [1:0]  vec_widx_i,
    input  logic [15:0] vec_wdata_i,
    input  logic [15:0] cur_pc_i,
    input  logic        ret_strobe_i,
    output logic        take_o,
    output logic [1:0]  src_o,
    output logic [3:0]  ack_o,
    output logic [15:0] target_o,
    output logic        ret_valid_o,
    output logic [15:0] ret_pc_o
);
    src_vec_t mask_q;
    level_t   level_q;

    logic     pick_valid;
    src_idx_t pick_idx;
    addr_t    vec_rdata;

    frame_t   push_frame;
    frame_t   top_frame;
    logic     stk_empty;
    logic     stk_full;

    logic     take_go;
    logic     ret_go;

    vic_pick u_pick (
        .req_i   (irq_req_i),
        .mask_i  (mask_q),
        .level_i (level_q),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    vic_vecfile u_vec (
        .clk     (clk),
        .rst     (rst),
        .we_i    (vec_we_i),
        .widx_i  (vec_widx_i),
        .wdata_i (vec_wdata_i),
        .ridx_i  (pick_idx),
        .rdata_o (vec_rdata)
    );

    // return has precedence over recognition on the same edge
    assign ret_go  = ret_strobe_i && !stk_empty;
    assign take_go = insn_end_i && glob_en_i && pick_valid && !ret_strobe_i;

    assign push_frame.ret_addr = cur_pc_i + addr_t'(1);
    assign push_frame.prev_lvl = level_q;

    vic_rstack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (take_go),
        .pop_i       (ret_go),
        .push_data_i (push_frame),
        .top_o       (top_frame),
        .empty_o     (stk_empty),
        .full_o      (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q     <= LVL_IDLE;
            take_o      <= 1'b0;
            src_o       <= '0;
            ack_o       <= '0;
            target_o    <= '0;
            ret_valid_o <= 1'b0;
            ret_pc_o    <= '0;
        end else begin
            take_o      <= take_go;
            ret_valid_o <= ret_go;
            ack_o       <= take_go ? idx_to_onehot(pick_idx) : '0;
            if (take_go) begin
                level_q  <= level_t'(pick_idx);
                src_o    <= pick_idx;
                target_o <= vec_rdata;
            end else if (ret_go) begin
                level_q  <= top_frame.prev_lvl;
                ret_pc_o <= top_frame.ret_addr;
            end
        end
    end

    assert_take_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(insn_end_i));
    assert_take_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(glob_en_i));
    assert_masked_silent_R5: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (($past(mask_q) & ack_o) == '0));
    assert_ack_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o) && (take_o == (ack_o != '0)));
    assert_ack_matches_src_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ack_o[src_o]);
    assert_ack_was_requested_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (($past(irq_req_i) & ack_o) == ack_o));
    assert_ret_blocks_take_R10: assert property (@(posedge clk) disable iff (rst)
        $past(ret_strobe_i) |-> !take_o);
    assert_ret_follows_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        ret_valid_o |-> $past(ret_strobe_i));
    assert_stack_room_R8: assert property (@(posedge clk) disable iff (rst)
        take_go |-> !stk_full);

endmodule

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_end_i;
    logic        glob_en_i;
    logic [3:0]  irq_req_i;
    logic        mask_we_i;
    logic [3:0]  mask_wdata_i;
    logic        vec_we_i;
    logic [1:0]  vec_widx_i;
    logic [15:0] vec_wdata_i;
    logic [15:0] cur_pc_i;
    logic        ret_strobe_i;
    logic        take_o;
    logic [1:0]  src_o;
    logic [3:0]  ack_o;
    logic [15:0] target_o;
    logic        ret_valid_o;
    logic [15:0] ret_pc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vec_irq_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .insn_end_i   (insn_end_i),
        .glob_en_i    (glob_en_i),
        .irq_req_i    (irq_req_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .vec_we_i     (vec_we_i),
        .vec_widx_i   (vec_widx_i),
        .vec_wdata_i  (vec_wdata_i),
        .cur_pc_i     (cur_pc_i),
        .ret_strobe_i (ret_strobe_i),
        .take_o       (take_o),
        .src_o        (src_o),
        .ack_o        (ack_o),
        .target_o     (target_o),
        .ret_valid_o  (ret_valid_o),
        .ret_pc_o     (ret_pc_o)
    );

    // row: {glob_en[11], mask[10:7], req[6:3], exp_take[2], exp_idx[1:0]}
    localparam int NROW = 9;
    localparam logic [11:0] ROWS [NROW] = '{
        {1'b1, 4'b0000, 4'b0001, 1'b1, 2'd0},
        {1'b1, 4'b0000, 4'b1100, 1'b1, 2'd2},
        {1'b1, 4'b0000, 4'b1000, 1'b1, 2'd3},
        {1'b1, 4'b0000, 4'b1110, 1'b1, 2'd1},
        {1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0},
        {1'b1, 4'b0001, 4'b0001, 1'b0, 2'd0},
        {1'b1, 4'b0011, 4'b1011, 1'b1, 2'd3},
        {1'b1, 4'b1111, 4'b1111, 1'b0, 2'd0},
        {1'b1, 4'b0000, 4'b0000, 1'b0, 2'd0}
    };

    function automatic logic [15:0] vec_addr(int i);
        return 16'h1000 + 16'(i) * 16'h0110;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive strobes for one edge, then sample the registered outputs
    task automatic step(logic ie, logic rs);
        @(negedge clk);
        insn_end_i   = ie;
        ret_strobe_i = rs;
        @(negedge clk);
        insn_end_i   = 1'b0;
        ret_strobe_i = 1'b0;
    endtask

    task automatic set_mask(logic [3:0] m);
        @(negedge clk);
        mask_we_i    = 1'b1;
        mask_wdata_i = m;
        @(negedge clk);
        mask_we_i    = 1'b0;
    endtask

    task automatic set_vec(logic [1:0] i, logic [15:0] a);
        @(negedge clk);
        vec_we_i    = 1'b1;
        vec_widx_i  = i;
        vec_wdata_i = a;
        @(negedge clk);
        vec_we_i    = 1'b0;
    endtask

    task automatic expect_take(string req, logic [1:0] idx, logic [15:0] tgt);
        chk(req, 32'(take_o), 32'd1);
        chk(req, 32'(src_o), 32'(idx));
        chk(req, 32'(ack_o), 32'(4'b0001 << idx));
        chk(req, 32'(target_o), 32'(tgt));
    endtask

    task automatic expect_none(string req);
        chk(req, 32'(take_o), 32'd0);
        chk(req, 32'(ack_o), 32'd0);
    endtask

    task automatic expect_ret(string req, logic [15:0] pc);
        chk(req, 32'(ret_valid_o), 32'd1);
        chk(req, 32'(ret_pc_o), 32'(pc));
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst          = 1'b1;
        insn_end_i   = 1'b0;
        glob_en_i    = 1'b0;
        irq_req_i    = '0;
        mask_we_i    = 1'b0;
        mask_wdata_i = '0;
        vec_we_i     = 1'b0;
        vec_widx_i   = '0;
        vec_wdata_i  = '0;
        cur_pc_i     = '0;
        ret_strobe_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 take", 32'(take_o), 32'd0);
        chk("R1 ack", 32'(ack_o), 32'd0);
        chk("R1 ret_valid", 32'(ret_valid_o), 32'd0);
        step(1'b0, 1'b1);
        chk("R1 empty stack", 32'(ret_valid_o), 32'd0);

        for (int i = 0; i < 4; i++) set_vec(2'(i), vec_addr(i));

        // R1: mask resets to all unmasked, level idle
        glob_en_i = 1'b1;
        irq_req_i = 4'b1000;
        cur_pc_i  = 16'h0010;
        step(1'b1, 1'b0);
        expect_take("R1 unmasked after reset", 2'd3, vec_addr(3));
        irq_req_i = '0;
        step(1'b0, 1'b1);
        expect_ret("R7 first return", 16'h0011);

        // R2: no strobe, no recognition
        irq_req_i = 4'b0001;
        step(1'b0, 1'b0);
        expect_none("R2 no insn_end");
        irq_req_i = '0;

        // table walk: R3 R4 R5 R6 R7 R10 R11
        for (int k = 0; k < NROW; k++) begin
            logic [11:0] r;
            r = ROWS[k];
            set_mask(r[10:7]);
            glob_en_i = r[11];
            irq_req_i = r[6:3];
            cur_pc_i  = 16'h0200 + 16'(k);
            step(1'b1, 1'b0);
            if (r[2]) expect_take("R3 R4 R5 R11 table", r[1:0], vec_addr(int'(r[1:0])));
            else      expect_none("R5 R6 table");
            irq_req_i = '0;
            step(1'b0, 1'b1);
            if (r[2]) expect_ret("R7 table", 16'h0201 + 16'(k));
            else      chk("R10 empty return", 32'(ret_valid_o), 32'd0);
        end
        set_mask(4'b0000);
        glob_en_i = 1'b1;

        // R8 / R9 nesting
        irq_req_i = 4'b0100; cur_pc_i = 16'h0050;
        step(1'b1, 1'b0);
        expect_take("R8 first level", 2'd2, vec_addr(2));
        irq_req_i = 4'b0001; cur_pc_i = 16'h0080;
        step(1'b1, 1'b0);
        expect_take("R8 nest higher", 2'd0, vec_addr(0));
        irq_req_i = 4'b1100; cur_pc_i = 16'h0090;
        step(1'b1, 1'b0);
        expect_none("R8 held under level 0");
        step(1'b0, 1'b1);
        expect_ret("R9 inner return", 16'h0081);
        cur_pc_i = 16'h00A0;
        step(1'b1, 1'b0);
        expect_none("R9 level restored to 2 holds 2 and 3");
        irq_req_i = 4'b0010; cur_pc_i = 16'h00B0;
        step(1'b1, 1'b0);
        expect_take("R8 nest index 1 over 2", 2'd1, vec_addr(1));
        irq_req_i = '0;
        step(1'b0, 1'b1);
        expect_ret("R9 return from 1", 16'h00B1);
        step(1'b0, 1'b1);
        expect_ret("R9 return from 2", 16'h0051);
        step(1'b0, 1'b1);
        chk("R10 stack drained", 32'(ret_valid_o), 32'd0);
        irq_req_i = 4'b1000; cur_pc_i = 16'h00C0;
        step(1'b1, 1'b0);
        expect_take("R9 idle after unwind", 2'd3, vec_addr(3));
        irq_req_i = '0;
        step(1'b0, 1'b1);
        expect_ret("R7 return idle", 16'h00C1);

        // R9: four deep, LIFO
        for (int d = 0; d < 4; d++) begin
            irq_req_i = 4'b1000 >> d;
            cur_pc_i  = 16'h0300 + 16'(d);
            step(1'b1, 1'b0);
            expect_take("R9 deep push", 2'(3 - d), vec_addr(3 - d));
        end
        irq_req_i = '0;
        for (int d = 3; d >= 0; d--) begin
            step(1'b0, 1'b1);
            expect_ret("R9 deep pop", 16'h0301 + 16'(d));
        end

        // R10: return and boundary on the same edge
        irq_req_i = 4'b0100; cur_pc_i = 16'h0400;
        step(1'b1, 1'b0);
        expect_take("R10 setup", 2'd2, vec_addr(2));
        irq_req_i = 4'b0001;
        step(1'b1, 1'b1);
        expect_ret("R10 return wins", 16'h0401);
        expect_none("R10 no take with return");
        step(1'b1, 1'b1);
        chk("R10 empty return with strobe", 32'(ret_valid_o), 32'd0);
        expect_none("R10 strobe blocks take");
        irq_req_i = '0;

        // R4: rewritten vector
        set_vec(2'd3, 16'hBEEF);
        irq_req_i = 4'b1000; cur_pc_i = 16'hFFFF;
        step(1'b1, 1'b0);
        expect_take("R4 rewritten vector", 2'd3, 16'hBEEF);
        irq_req_i = '0;
        step(1'b0, 1'b1);
        expect_ret("R7 address wrap", 16'h0000);

        // R6: disable during service blocks nesting too
        irq_req_i = 4'b0100; cur_pc_i = 16'h0500;
        step(1'b1, 1'b0);
        expect_take("R6 setup", 2'd2, vec_addr(2));
        glob_en_i = 1'b0;
        irq_req_i = 4'b0001;
        step(1'b1, 1'b0);
        expect_none("R6 disabled nesting");
        glob_en_i = 1'b1;
        step(1'b1, 1'b0);
        expect_take("R6 re-enabled nesting", 2'd0, vec_addr(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule